// File: doc/BRIEF.md
# Gated Programmable Clock Divider

This block derives one output clock from the clock it runs on. The division ratio comes from a small divisor field. A gate bit switches the output on and off. Both are written through a simple single-cycle register port, which also reads them back together with a status word.

A divisor write does not act at once. The write raises a busy indication. The new ratio is loaded only when the output period that is running completes, and busy drops on that same edge. Software therefore polls busy before and after each write. Gate changes are also applied only at a period boundary, so the output never shows a shortened pulse.

A build parameter picks the field format. The narrow format is a 5-bit divisor. The wide format adds a sixth bit that engages a fixed divide-by-64 prescale on the lower five bits.

Top module: `cgd_top`

## Requirements
- R1: After reset the divisor field reads 0, the gate bit reads 0, the status word reads 0, and `clk_o` stays low.
- R2: In the narrow format (WIDE=0) a field value k from 1 to 31 gives a ratio of k, and a field value of 0 gives a ratio of 32.
- R3: In the wide format (WIDE=1), when bit 5 is clear the ratio is bits 4:0. When bit 5 is set the ratio is 64 times bits 4:0. A product or value of 0 selects a ratio of 64.
- R4: A ratio of 1 passes the input clock through while gated on. A ratio N of 2 or more gives floor(N/2) cycles high followed by N-floor(N/2) cycles low.
- R5: Register map on `addr_i`: 0 is the divisor field (zero-extended), 1 is the gate bit in bit 0, 2 is status (bits 4 and 3 both set while busy, bit 0 the error flag), and 3 reads as zero.
- R6: An accepted divisor write sets busy. The new ratio first applies to the output period that starts after the current one ends, and busy clears on that boundary edge.
- R7: A divisor write whose value exceeds the field mask (31 narrow, 63 wide) leaves the stored field unchanged and sets the error flag.
- R8: A divisor write while busy is ignored and sets the error flag. The error flag stays set until reset, even across later valid writes.
- R9: The gate bit reads back as written and takes effect only at a period boundary. A high pulse in progress when the gate is cleared completes at full length, and the output then stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select for reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for `addr_i` |
| clk_o | output | 1 | Gated, divided output clock |

## Verification
Both formats are swept over every field value from 0 to 31, which separates the zero-means-maximum rule from the plain ratios. The wide format additionally gets prescaled values, including bit 5 with zero low bits, to separate the times-64 path from the zero fallback. Each ratio is measured as high and low lengths in parent cycles, so odd ratios expose a swapped or misrounded duty split, and ratio 1 checks passthrough in both clock phases. Mid-period divisor and gate writes tell a boundary-aligned update apart from an immediate one. Back-to-back writes and over-mask values exercise the rejection and sticky-error paths.

// File: rtl/cgd_pkg.sv
package cgd_pkg;

    typedef enum logic [1:0] {
        REG_DIV  = 2'd0,
        REG_GATE = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } cgd_reg_e;

    // Effective ratio for a (zero-extended) divisor field.
    function automatic int unsigned cgd_ratio(input logic [5:0] field, input bit wide);
        int unsigned lo;
        int unsigned r;
        lo = int'(field[4:0]);
        if (wide && field[5]) r = 64 * lo;
        else                  r = lo;
        if (r == 0) r = wide ? 64 : 32;
        return r;
    endfunction

endpackage

// File: rtl/cgd_regs.sv
module cgd_regs
    import cgd_pkg::*;
#(
    parameter int FIELD_W = 5,
    parameter int DATA_W  = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               we_i,
    input  logic [1:0]         addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  logic               boundary_i,
    output logic [FIELD_W-1:0] field_o,
    output logic               en_o,
    output logic               busy_o,
    output logic               err_o,
    output logic [DATA_W-1:0]  rdata_o
);

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               en;
        logic               busy;
        logic               err;
    } regs_t;

    regs_t st_d, st_q;
    logic  over_w;

    assign over_w = |wdata_i[DATA_W-1:FIELD_W];

    always_comb begin
        st_d = st_q;
        if (st_q.busy && boundary_i) st_d.busy = 1'b0;
        if (we_i) begin
            case (cgd_reg_e'(addr_i))
                REG_DIV: begin
                    if (st_q.busy || over_w) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.field = wdata_i[FIELD_W-1:0];
                        st_d.busy  = 1'b1;
                    end
                end
                REG_GATE: st_d.en = wdata_i[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rdata_o = '0;
        case (cgd_reg_e'(addr_i))
            REG_DIV:  rdata_o[FIELD_W-1:0] = st_q.field;
            REG_GATE: rdata_o[0] = st_q.en;
            REG_STAT: begin
                rdata_o[4] = st_q.busy;
                rdata_o[3] = st_q.busy;
                rdata_o[0] = st_q.err;
            end
            default: ;
        endcase
    end

    assign field_o = st_q.field;
    assign en_o    = st_q.en;
    assign busy_o  = st_q.busy;
    assign err_o   = st_q.err;

endmodule

// File: rtl/cgd_ratio_dec.sv
module cgd_ratio_dec
    import cgd_pkg::*;
#(
    parameter bit WIDE    = 1'b0,
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 6
) (
    input  logic [FIELD_W-1:0] field_i,
    output logic [RATIO_W-1:0] ratio_o
);

    logic [5:0] field_ext;

    assign field_ext = 6'(field_i);
    assign ratio_o   = RATIO_W'(cgd_ratio(field_ext, WIDE));

endmodule

// File: rtl/cgd_divcore.sv
module cgd_divcore #(
    parameter int RATIO_W   = 6,
    parameter int RST_RATIO = 32
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               load_i,
    input  logic               gate_i,
    output logic               boundary_o,
    output logic [RATIO_W-1:0] ratio_o,
    output logic               gate_o,
    output logic               clk_o
);

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               gate;
        logic               phase;
    } core_t;

    core_t st_d, st_q;
    logic  last_w;
    logic  gate_lat;

    assign last_w = (st_q.cnt == st_q.ratio - RATIO_W'(1));

    always_comb begin
        st_d = st_q;
        if (last_w) begin
            st_d.cnt  = '0;
            st_d.gate = gate_i;
            if (load_i) st_d.ratio = ratio_i;
        end else begin
            st_d.cnt = st_q.cnt + RATIO_W'(1);
        end
        st_d.phase = st_d.gate && (st_d.cnt < (st_d.ratio >> 1));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q       <= '0;
            st_q.ratio <= RATIO_W'(RST_RATIO);
        end else begin
            st_q <= st_d;
        end
    end

    // Enable latch, transparent in the low phase: passthrough pulses are whole.
    always_latch begin
        if (!clk_i) gate_lat = st_q.gate;
    end

    assign clk_o      = (st_q.ratio == RATIO_W'(1)) ? (clk_i & gate_lat) : st_q.phase;
    assign boundary_o = last_w;
    assign ratio_o    = st_q.ratio;
    assign gate_o     = st_q.gate;

endmodule

// File: rtl/cgd_top.sv
module cgd_top #(
    parameter bit WIDE   = 1'b0,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              clk_o
);

    localparam int FIELD_W   = WIDE ? 6 : 5;
    localparam int MAX_RATIO = WIDE ? 64 * 31 : 32;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int RST_RATIO = WIDE ? 64 : 32;

    logic [FIELD_W-1:0] field_w;
    logic               en_w, busy_w, err_w, bound_w, gate_w;
    logic [RATIO_W-1:0] ratio_new_w, ratio_w;

    cgd_regs #(.FIELD_W(FIELD_W), .DATA_W(DATA_W)) u_regs (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .boundary_i (bound_w),
        .field_o    (field_w),
        .en_o       (en_w),
        .busy_o     (busy_w),
        .err_o      (err_w),
        .rdata_o    (rdata_o)
    );

    cgd_ratio_dec #(.WIDE(WIDE), .FIELD_W(FIELD_W), .RATIO_W(RATIO_W)) u_dec (
        .field_i (field_w),
        .ratio_o (ratio_new_w)
    );

    cgd_divcore #(.RATIO_W(RATIO_W), .RST_RATIO(RST_RATIO)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .ratio_i    (ratio_new_w),
        .load_i     (busy_w),
        .gate_i     (en_w),
        .boundary_o (bound_w),
        .ratio_o    (ratio_w),
        .gate_o     (gate_w),
        .clk_o      (clk_o)
    );

endmodule

// File: rtl/cgd_checker.sv
module cgd_checker #(
    parameter int FIELD_W = 5,
    parameter int RATIO_W = 6,
    parameter int DATA_W  = 8
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               we_i,
    input logic [1:0]         addr_i,
    input logic [DATA_W-1:0]  wdata_i,
    input logic [FIELD_W-1:0] field_i,
    input logic               busy_i,
    input logic               err_i,
    input logic               bound_i,
    input logic [RATIO_W-1:0] ratio_i,
    input logic               gate_i
);

    logic div_wr, too_big;
    assign div_wr  = we_i && (addr_i == 2'd0);
    assign too_big = (wdata_i >> FIELD_W) != '0;

    p_busy_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && !bound_i |=> busy_i);
    p_busy_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && bound_i |=> !busy_i);
    p_ratio_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(busy_i && bound_i) |=> $stable(ratio_i));
    p_ratio_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ratio_i != '0);
    p_gate_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bound_i |=> $stable(gate_i));
    p_over_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_wr && too_big |=> $stable(field_i) && err_i);
    p_busy_ignore_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        div_wr && busy_i |=> $stable(field_i) && err_i);
    p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_i |=> err_i);

endmodule

bind cgd_top cgd_checker #(.FIELD_W(FIELD_W), .RATIO_W(RATIO_W), .DATA_W(DATA_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .field_i (field_w),
    .busy_i  (busy_w),
    .err_i   (err_w),
    .bound_i (bound_w),
    .ratio_i (ratio_w),
    .gate_i  (gate_w)
);

// File: tb/cgd_top_test.sv
module cgd_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we_n = 1'b0, we_w = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rd_n, rd_w;
    logic       co_n, co_w;
    logic       smp;
    int         vecs = 0;
    int         errs = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    cgd_top #(.WIDE(1'b0), .DATA_W(8)) uut (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we_n), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rd_n), .clk_o(co_n));

    cgd_top #(.WIDE(1'b1), .DATA_W(8)) uut_w (
        .clk_i(clk), .rst_ni(rst_n), .we_i(we_w), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rd_w), .clk_o(co_w));

    function automatic int exp_ratio(int f, bit wide);
        int r;
        r = f % 32;
        if (wide && f >= 32) r = 64 * r;
        if (r == 0) r = wide ? 64 : 32;
        return r;
    endfunction

    task automatic chk(string req, int act, int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(bit w);
        @(posedge clk); #2;
        smp = w ? co_w : co_n;
    endtask

    task automatic wr(bit w, logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we_w = w; we_n = !w;
        @(negedge clk);
        we_w = 1'b0; we_n = 1'b0;
    endtask

    task automatic rd(bit w, logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; #1;
        d = w ? rd_w : rd_n;
    endtask

    task automatic wait_idle(bit w);
        logic [7:0] s;
        bit idle;
        idle = 1'b0;
        for (int i = 0; i < 6000 && !idle; i++) begin
            rd(w, 2'd2, s);
            if (s[4:3] == 2'b00) idle = 1'b1;
        end
        if (!idle) chk("R6 busy never cleared", 1, 0);
    endtask

    task automatic sync(bit w);
        logic prev;
        bit hit;
        hit = 1'b0;
        tick(w); prev = smp;
        for (int i = 0; i < 5000 && !hit; i++) begin
            tick(w);
            if (!prev && smp) hit = 1'b1;
            prev = smp;
        end
    endtask

    task automatic period(bit w, output int h, output int l);
        bit stop;
        h = 1; stop = 1'b0;
        for (int i = 0; i < 5000 && !stop; i++) begin
            tick(w);
            if (!smp) stop = 1'b1; else h++;
        end
        l = 1; stop = 1'b0;
        for (int i = 0; i < 5000 && !stop; i++) begin
            tick(w);
            if (smp) stop = 1'b1; else l++;
        end
    endtask

    task automatic check_ratio(bit w, int n, string req);
        int h, l, bad;
        if (n == 1) begin
            bad = 0;
            for (int i = 0; i < 6; i++) begin
                tick(w);
                if (smp !== 1'b1) bad++;
                @(negedge clk); #2;
                if ((w ? co_w : co_n) !== 1'b0) bad++;
            end
            chk({req, " passthrough samples wrong"}, bad, 0);
        end else begin
            sync(w);
            period(w, h, l);
            chk({req, " high length"}, h, n / 2);
            chk({req, " low length"}, l, n - n / 2);
        end
    endtask

    task automatic set_div(bit w, int f, string req);
        logic [7:0] d;
        wr(w, 2'd0, 8'(f));
        wait_idle(w);
        rd(w, 2'd0, d);
        chk({req, " R5 field readback"}, int'(d), f);
        check_ratio(w, exp_ratio(f, w), req);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int h, l, bad;
        int wide_list[6] = '{32, 33, 34, 35, 47, 63};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values and a silent output
        for (int w = 0; w < 2; w++) begin
            rd(w[0], 2'd0, d); chk("R1 divisor after reset", int'(d), 0);
            rd(w[0], 2'd1, d); chk("R1 gate after reset", int'(d), 0);
            rd(w[0], 2'd2, d); chk("R1 status after reset", int'(d), 0);
            rd(w[0], 2'd3, d); chk("R5 unused address", int'(d), 0);
            bad = 0;
            for (int i = 0; i < 140; i++) begin
                tick(w[0]);
                if (smp !== 1'b0) bad++;
            end
            chk("R1 output low while gated", bad, 0);
        end

        // R9: gate on, readback
        for (int w = 0; w < 2; w++) begin
            wr(w[0], 2'd1, 8'h01);
            rd(w[0], 2'd1, d); chk("R9 gate readback", int'(d), 1);
        end
        check_ratio(1'b0, 32, "R2 reset ratio narrow");

        // R2, R4: narrow sweep
        for (int f = 1; f < 32; f++) set_div(1'b0, f, "R2 R4 narrow");
        set_div(1'b0, 0, "R2 zero field narrow");

        // R3, R4: wide sweep
        for (int f = 1; f < 32; f++) set_div(1'b1, f, "R3 R4 wide low");
        set_div(1'b1, 0, "R3 zero field wide");
        foreach (wide_list[i]) set_div(1'b1, wide_list[i], "R3 wide prescaled");

        rd(1'b0, 2'd2, d); chk("R8 no error after valid writes", int'(d), 0);

        // R6: ratio change lands at the period boundary
        set_div(1'b0, 8, "R6 setup");
        sync(1'b0);
        fork
            wr(1'b0, 2'd0, 8'd4);
        join_none
        period(1'b0, h, l);
        chk("R6 current period high kept", h, 4);
        chk("R6 current period low kept", l, 4);
        period(1'b0, h, l);
        chk("R6 next period high new", h, 2);
        chk("R6 next period low new", l, 2);
        wait_idle(1'b0);

        // R9: gating off mid pulse, then back on
        set_div(1'b0, 10, "R9 setup");
        sync(1'b0);
        fork
            wr(1'b0, 2'd1, 8'h00);
        join_none
        h = 1;
        for (int i = 0; i < 20 && smp; i++) begin
            tick(1'b0);
            if (smp) h++;
        end
        chk("R9 last pulse full length", h, 5);
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            tick(1'b0);
            if (smp !== 1'b0) bad++;
        end
        chk("R9 output low after gate off", bad, 0);
        rd(1'b0, 2'd1, d); chk("R9 gate readback off", int'(d), 0);
        wr(1'b0, 2'd1, 8'h01);
        check_ratio(1'b0, 10, "R9 first pulses after gate on");

        // R8: write while busy is dropped, error is sticky
        wr(1'b0, 2'd0, 8'd0);
        wr(1'b0, 2'd0, 8'd3);
        wait_idle(1'b0);
        rd(1'b0, 2'd0, d); chk("R8 busy write ignored", int'(d), 0);
        rd(1'b0, 2'd2, d); chk("R8 error flag set", int'(d), 1);
        check_ratio(1'b0, 32, "R8 ratio from first write");
        set_div(1'b0, 6, "R8 later valid write");
        rd(1'b0, 2'd2, d); chk("R8 error flag sticky", int'(d), 1);
        wr(1'b0, 2'd0, 8'h20);
        rd(1'b0, 2'd0, d); chk("R7 narrow over-mask ignored", int'(d), 6);

        // R7: over-mask write on the wide format
        wr(1'b1, 2'd0, 8'h40);
        rd(1'b1, 2'd0, d); chk("R7 wide over-mask ignored", int'(d), 63);
        rd(1'b1, 2'd2, d); chk("R7 error flag set, not busy", int'(d), 1);
        check_ratio(1'b1, 1984, "R7 ratio unchanged");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule